// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a direct-mapped, write-back, write-allocate cache that sits between a CPU issuing byte reads and writes and a slower main memory that is reached one byte beat at a time. The CPU address is split into a tag, a line index and a byte offset. Each line keeps a valid flag, a dirty flag, a stored tag and one block of data bytes. A hit is answered in the same cycle that the request is presented.

On a miss the controller stalls the CPU and runs a fixed sequence. It checks valid, compares the tag and checks dirty. If the line is dirty it writes the old block back. It then fills the line and performs the pending access. The write-back address is built from the stored tag, with the line index and the beat number appended. Reads and writes take the same path, so a write miss allocates the line. Written bytes reach main memory only when their line is evicted.

With the default parameters the cache holds 256 lines of 16 bytes on a 24-bit address. Every width is a parameter.

Top module: `dm_wb_cache`

## Requirements
- R1: The CPU address splits into tag = bits [ADDR_W-1 : LINES_W+OFS_W], line index = bits [LINES_W+OFS_W-1 : OFS_W] and offset = bits [OFS_W-1:0]. With the defaults (24, 8, 4), 0xAB7129 gives tag 0xAB7, line 0x12 and offset 0x9. Every memory beat address is {tag, line, beat number}.
- R2: After reset no line is valid or dirty, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R3: An access to a line that is not valid goes straight to the fill, with no write-back beats.
- R4: A valid line whose stored tag equals the address tag is a hit. `cpu_ready` rises in the same cycle as the request, with no memory traffic. A read hit returns the addressed byte on `cpu_rdata`.
- R5: A tag mismatch on a clean valid line fills the line without a write-back.
- R6: A tag mismatch on a dirty line first writes all 2^OFS_W bytes of the old block to {stored tag, line, beat}, with `mem_we` = 1. The fill starts only after that.
- R7: After the last fill beat is acknowledged, the line is valid and clean. The pending access completes, with `cpu_ready` high, in the next cycle.
- R8: A write hit changes only the addressed byte and marks the line dirty. Main memory is not written until the line is replaced.
- R9: A write miss runs the same miss sequence and then writes the byte into the allocated line.
- R10: Beats go offset 0 first and then ascending. `mem_req` stays high with a stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`, and each cycle with `mem_ack` high completes one beat. `mem_we` = 1 means a write-back and 0 means a fill.
- R11: `cpu_ready` is low whenever `mem_req` is high. It pulses for one cycle per request. The CPU holds the request until that pulse and issues nothing new before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | DATA_W | Write byte |
| cpu_rdata | output | DATA_W | Read byte, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_wdata | output | DATA_W | Byte written by a write-back beat |
| mem_rdata | input | DATA_W | Byte returned for a fill beat |
| mem_ack | input | 1 | Completes the current beat |

## Verification
The bench builds the cache with a 12-bit address, 4 lines and 4-byte blocks. That gives 8-bit tags and 4-beat transfers. Because there are so few lines, conflict evictions of dirty and clean lines come up within a handful of accesses. The random phase can therefore cover write-back followed by fill, clean replacement and write allocation many times over, with short bursts and varied acknowledge delays. A behavioural model predicts every memory beat (direction, address and write-back byte) and the byte each read must return.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int LINES_W = 8,
   parameter int TAG_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LINES_W-1:0] idx,
   input  logic               mark_dirty,
   input  logic               fill_done,
   input  logic [TAG_W-1:0]   fill_tag,
   output logic               rd_valid,
   output logic               rd_dirty,
   output logic [TAG_W-1:0]   rd_tag
);
   localparam int NUM_LINES = 1 << LINES_W;

   logic [NUM_LINES-1:0] valid_q;
   logic [NUM_LINES-1:0] dirty_q;
   logic [TAG_W-1:0]     tag_q [NUM_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_done) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (mark_dirty) begin
         dirty_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_done) tag_q[idx] <= fill_tag;
   end

   assign rd_valid = valid_q[idx];
   assign rd_dirty = dirty_q[idx];
   assign rd_tag   = tag_q[idx];

   AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_q & ~valid_q) == '0); // R2
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int LINES_W = 8,
   parameter int OFS_W   = 4,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic [LINES_W-1:0] idx,
   input  logic               wr_en,
   input  logic [OFS_W-1:0]   wr_ofs,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_bytes [1<<OFS_W]
);
   localparam int NUM_LINES = 1 << LINES_W;
   localparam int BYTES     = 1 << OFS_W;
   localparam int LINE_BITS = BYTES * DATA_W;

   logic [LINE_BITS-1:0] line_q [NUM_LINES];

   always_ff @(posedge clk) begin
      if (wr_en) line_q[idx][wr_ofs*DATA_W +: DATA_W] <= wr_data;
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign rd_bytes[b] = line_q[idx][b*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/cache_miss_fsm.sv
module cache_miss_fsm
   import cache_pkg::*;
#(
   parameter int OFS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             hit,
   input  logic             victim_dirty,
   input  logic             mem_ack,
   output cache_state_e     state,
   output logic [OFS_W-1:0] beat,
   output logic             fill_we,
   output logic             fill_done
);
   localparam logic [OFS_W-1:0] LAST_BEAT = '1;
   localparam logic [OFS_W-1:0] ONE_BEAT  = OFS_W'(1);

   cache_state_e     state_q;
   logic [OFS_W-1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cpu_req && !hit) begin
                  beat_q  <= '0;
                  state_q <= victim_dirty ? ST_WBACK : ST_FILL;
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  beat_q <= beat_q + ONE_BEAT;
                  if (beat_q == LAST_BEAT) state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  beat_q <= beat_q + ONE_BEAT;
                  if (beat_q == LAST_BEAT) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state     = state_q;
   assign beat      = beat_q;
   assign fill_we   = (state_q == ST_FILL) && mem_ack;
   assign fill_done = fill_we && (beat_q == LAST_BEAT);

   AST_IDLE_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (beat_q == '0)); // R10
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
   import cache_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int LINES_W = 8,
   parameter int OFS_W   = 4,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int TAG_W = ADDR_W - LINES_W - OFS_W;
   localparam int BYTES = 1 << OFS_W;

   if (TAG_W < 1) begin : g_bad_split
      $error("address too narrow for line and offset fields");
   end
   if (OFS_W < 1 || LINES_W < 1) begin : g_bad_geom
      $error("line and offset fields need at least one bit");
   end

   logic [TAG_W-1:0]   addr_tag;
   logic [LINES_W-1:0] addr_idx;
   logic [OFS_W-1:0]   addr_ofs;

   assign addr_tag = cpu_addr[ADDR_W-1 -: TAG_W];
   assign addr_idx = cpu_addr[OFS_W +: LINES_W];
   assign addr_ofs = cpu_addr[OFS_W-1:0];

   logic             rd_valid, rd_dirty;
   logic [TAG_W-1:0] rd_tag;
   logic             hit, victim_dirty, wr_hit;
   cache_state_e     state;
   logic [OFS_W-1:0] beat;
   logic             fill_we, fill_done;
   logic [DATA_W-1:0] rd_bytes [BYTES];

   assign hit          = rd_valid && (rd_tag == addr_tag);
   assign victim_dirty = rd_valid && rd_dirty;
   assign cpu_ready    = (state == ST_IDLE) && cpu_req && hit;
   assign wr_hit       = cpu_ready && cpu_we;

   cache_tag_store #(.LINES_W(LINES_W), .TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (addr_idx),
      .mark_dirty (wr_hit),
      .fill_done  (fill_done),
      .fill_tag   (addr_tag),
      .rd_valid   (rd_valid),
      .rd_dirty   (rd_dirty),
      .rd_tag     (rd_tag)
   );

   cache_data_store #(.LINES_W(LINES_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_data (
      .clk      (clk),
      .idx      (addr_idx),
      .wr_en    (fill_we || wr_hit),
      .wr_ofs   (fill_we ? beat : addr_ofs),
      .wr_data  (fill_we ? mem_rdata : cpu_wdata),
      .rd_bytes (rd_bytes)
   );

   cache_miss_fsm #(.OFS_W(OFS_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_req      (cpu_req),
      .hit          (hit),
      .victim_dirty (victim_dirty),
      .mem_ack      (mem_ack),
      .state        (state),
      .beat         (beat),
      .fill_we      (fill_we),
      .fill_done    (fill_done)
   );

   assign cpu_rdata = rd_bytes[addr_ofs];
   assign mem_req   = (state != ST_IDLE);
   assign mem_we    = (state == ST_WBACK);
   assign mem_addr  = {(mem_we ? rd_tag : addr_tag), addr_idx, beat};
   assign mem_wdata = rd_bytes[beat];

   AST_STALL_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready); // R11
   AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
   AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack && (&mem_addr[OFS_W-1:0])) |=> (mem_req && !mem_we)); // R6
   AST_FILL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> cpu_ready); // R7
endmodule

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
   localparam int AW = 12;
   localparam int LW = 2;
   localparam int OW = 2;
   localparam int DW = 8;
   localparam int NB = 1 << OW;
   localparam int NL = 1 << LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_ready;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ack = 1'b0;

   always #5 clk = ~clk;

   dm_wb_cache #(.ADDR_W(AW), .LINES_W(LW), .OFS_W(OW), .DATA_W(DW)) u_dm_wb_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   int errors = 0;
   int checks = 0;
   logic [7:0] main_mem [1<<AW];
   logic [7:0] ref_mem  [1<<AW];
   bit mv [NL];
   bit md [NL];
   int mt [NL];
   int q_we[$], q_addr[$], q_data[$], q_last[$];
   int cycles = 0;
   int rsp_seed = 7;
   int rsp_delay = 0;
   bit waiting = 0;
   int hold_addr = 0;
   bit last_fill = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
         finish_run();
      end
   end

   // memory model: acknowledges beats after 0..2 cycles, checks each against the prediction
   always @(negedge clk) begin
      if (rst_n) begin
         if (last_fill) begin
            chk("R7 ready after last fill", int'(cpu_ready), 1);
            last_fill = 0;
         end
         if (cpu_ready && q_addr.size() != 0) chk("R11 ready with beats pending", 1, 0);
         if (mem_ack) begin
            mem_ack = 1'b0;
            waiting = 0;
         end
         if (mem_req) begin
            if (waiting) chk("R10 address held", int'(mem_addr), hold_addr);
            if (rsp_delay > 0) begin
               rsp_delay--;
               waiting = 1;
               hold_addr = int'(mem_addr);
            end else begin
               if (q_addr.size() == 0) begin
                  chk("R4 unexpected memory beat", int'(mem_addr), -1);
               end else begin
                  chk("R10 beat direction", int'(mem_we), q_we[0]);
                  chk("R1 beat address", int'(mem_addr), q_addr[0]);
                  if (mem_we) chk("R6 write-back byte", int'(mem_wdata), q_data[0]);
                  if (q_last[0] != 0) last_fill = 1;
                  void'(q_we.pop_front()); void'(q_addr.pop_front());
                  void'(q_data.pop_front()); void'(q_last.pop_front());
               end
               if (mem_we) main_mem[mem_addr] = mem_wdata;
               mem_rdata = main_mem[mem_addr];
               mem_ack = 1'b1;
               rsp_seed = rsp_seed * 1103515245 + 12345;
               rsp_delay = (rsp_seed >>> 16) & 3;
               if (rsp_delay == 3) rsp_delay = 0;
            end
         end
      end
   end

   task automatic access(input bit we, input int addr, input int wd, input string req);
      int line, tag, base, cyc;
      bit hit;
      line = (addr >> OW) % NL;
      tag  = addr >> (OW + LW);
      base = addr & ~(NB - 1);
      hit  = mv[line] && (mt[line] == tag);
      if (!hit) begin
         if (mv[line] && md[line]) begin
            for (int b = 0; b < NB; b++) begin
               int wa = (mt[line] << (OW + LW)) | (line << OW) | b;
               q_we.push_back(1); q_addr.push_back(wa);
               q_data.push_back(int'(ref_mem[wa])); q_last.push_back(0);
            end
         end
         for (int b = 0; b < NB; b++) begin
            q_we.push_back(0); q_addr.push_back(base + b);
            q_data.push_back(0); q_last.push_back(b == NB - 1 ? 1 : 0);
         end
         mv[line] = 1; mt[line] = tag; md[line] = 0;
      end
      if (we) md[line] = 1;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(addr); cpu_wdata = DW'(wd);
      #1;
      cyc = 0;
      while (!cpu_ready) begin
         @(negedge clk); #1;
         cyc++;
      end
      if (hit) chk({req, " hit in request cycle"}, cyc, 0);
      else     chk({req, " all beats done at ready"}, q_addr.size(), 0);
      if (!we) chk({req, " read byte"}, int'(cpu_rdata), int'(ref_mem[addr]));
      else     ref_mem[addr] = DW'(wd);
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      chk("R11 single ready pulse", int'(cpu_ready), 0);
   endtask

   initial begin
      int seed;
      int old;
      for (int i = 0; i < (1 << AW); i++) begin
         main_mem[i] = 8'((i * 37 + 11) & 255);
         ref_mem[i]  = main_mem[i];
      end
      repeat (3) @(negedge clk);
      chk("R2 reset ready low", int'(cpu_ready), 0);
      chk("R2 reset mem_req low", int'(mem_req), 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R2 idle after reset", int'(mem_req), 0);

      access(0, 'h123, 0, "R3 R2 cold read");
      access(0, 'h122, 0, "R4 read hit");
      old = int'(main_mem['h121]);
      access(1, 'h121, 'hA5, "R8 write hit");
      chk("R8 memory untouched", int'(main_mem['h121]), old);
      access(0, 'h121, 0, "R8 readback");
      access(0, 'h120, 0, "R8 neighbour intact");
      access(0, 'h523, 0, "R6 dirty eviction");
      chk("R6 written back", int'(main_mem['h121]), 'hA5);
      access(0, 'h121, 0, "R5 clean replacement");
      access(1, 'h7A8, 'h3C, "R9 write miss");
      access(0, 'h7A8, 0, "R9 allocated readback");
      access(0, 'h7A9, 0, "R9 rest filled");

      seed = 99;
      for (int n = 0; n < 400; n++) begin
         int a, w;
         seed = seed * 1103515245 + 12345;
         a = (seed >>> 8) & 255;
         w = (seed >>> 20) & 1;
         access(w[0], a, (seed >>> 4) & 255, "R1 R7 mixed");
      end
      finish_run();
   end
endmodule